// File: doc/BRIEF.md
# Posit8 Multiply-Accumulate Quire

This block accumulates dot products of 8-bit posit numbers (two exponent bits) without rounding the running sum. On each clock edge where the accumulate strobe is high, it decodes both operand bytes into sign, scale and significand. It then forms their exact product, aligns that product to a 32-bit two's-complement fixed-point register with 16 integer and 16 fraction bits, and adds it in. Product bits finer than 2^-16 are cut off toward zero. Everything else is kept exactly.

Sums that leave the register's range saturate to the extreme with the correct sign. A sticky overflow flag records that this happened. An operand equal to the not-a-real code leaves the register alone and raises a sticky flag of its own. A clear strobe starts a fresh dot product by zeroing the register and both flags. The register value is exported raw; turning it back into a posit is left to downstream logic.

Top module: `posit_quire_mac`

## Requirements
- R1: While reset is asserted and after it is released, the quire reads 0x00000000 and both flags read 0.
- R2: On each rising edge with `acc_en` high and `clr_en` low, the exact product of the two decoded operands is added to the quire. Quire bit n has weight 2^(n-16) (for example, 1.0 is 0x00010000). A posit word has a sign bit, a regime run, then up to 2 exponent bits, then fraction bits with a hidden 1; the scale is 4*k+e.
- R3: A word with bit 7 set is negative and is decoded from its two's complement (0xC0 is -1.0). The product sign is the XOR of the operand signs.
- R4: An operand equal to 0x00 is zero: the accumulation leaves the quire and flags unchanged.
- R5: An operand equal to 0x80 is NaR: the quire keeps its value and `nar_flag` sets and stays set until a clear.
- R6: Product bits below 2^-16 are dropped by truncating the magnitude toward zero before the signed add (1.5625*2^-16 adds 1, its negative adds -1).
- R7: When quire plus product is above 0x7FFFFFFF, the quire becomes 0x7FFFFFFF. When it is below 0x80000000, the quire becomes 0x80000000. In both cases `ovf_flag` sets. A sum of exactly -2^15 (0x80000000) is not an overflow.
- R8: A product whose magnitude is 2^15 or more sets `ovf_flag` and loads 0x7FFFFFFF (positive product) or 0x80000000 (negative product).
- R9: `ovf_flag` stays high through later accumulations until a clear.
- R10: A rising edge with `clr_en` high zeroes the quire and both flags. Any simultaneous accumulate is discarded.
- R11: With both strobes low, the quire and flags hold their values whatever the operand inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Accumulate the product of `opa` and `opb` on this edge |
| clr_en | input | 1 | Zero the quire and flags on this edge |
| opa | input | 8 | First posit operand |
| opb | input | 8 | Second posit operand |
| quire | output | 32 | Fixed-point accumulator, 16 fraction bits |
| ovf_flag | output | 1 | Sticky saturation indicator |
| nar_flag | output | 1 | Sticky not-a-real indicator |

## Verification
The bench builds the block with its defaults: 8-bit posits, two exponent bits, a 32-bit quire with 16 fraction bits. With those values, products of operands near 256 and 64 land at 2^14. Two or three accumulations then drive the quire to either rail, including the exact -2^15 boundary. Operands near 2^-8 give products just above 2^-16, which exercise truncation in both signs. The maximal posit and the NaR code reach the product-overflow and sticky-flag paths directly.

// File: rtl/posit_mac_pkg.sv
package posit_mac_pkg;

    // Classification of a decoded posit word
    typedef enum logic [1:0] {
        PCLS_ZERO = 2'd0,
        PCLS_NAR  = 2'd1,
        PCLS_NORM = 2'd2
    } pcls_e;

endpackage

// File: rtl/posit_decode.sv
module posit_decode
    import posit_mac_pkg::*;
#(
    parameter int PW = 8,
    parameter int ES = 2,
    localparam int FW  = PW - 3 - ES,
    localparam int SW  = FW + 1,
    localparam int SCW = $clog2(PW * (1 << ES)) + 2,
    localparam int RW  = $clog2(PW) + 1
) (
    input  logic [PW-1:0]         word,
    output pcls_e                 cls,
    output logic                  neg,
    output logic signed [SCW-1:0] scale,
    output logic [SW-1:0]         sig
);

    localparam logic [PW-2:0] ONE_B = {{(PW-2){1'b0}}, 1'b1};

    logic [PW-2:0]         body;
    logic                  lead;
    logic                  done;
    logic [RW-1:0]         run;
    logic [PW-4:0]         rest;
    logic [ES-1:0]         ex;
    logic [FW-1:0]         fr;
    logic signed [SCW-1:0] kval;

    always_comb begin
        body = word[PW-1] ? (~word[PW-2:0] + ONE_B) : word[PW-2:0];
        lead = body[PW-2];
        run  = '0;
        done = 1'b0;
        for (int i = PW - 2; i >= 0; i--) begin
            if (!done) begin
                if (body[i] == lead) run = run + RW'(1);
                else                 done = 1'b1;
            end
        end
        // bits after the shortest possible regime, realigned past the actual one
        rest  = body[PW-4:0] << (run - RW'(1));
        ex    = rest[PW-4 -: ES];
        fr    = rest[PW-4-ES -: FW];
        kval  = lead ? (SCW'(run) - SCW'(1)) : (SCW'(0) - SCW'(run));
        scale = (kval <<< ES) + SCW'(ex);
        sig   = {1'b1, fr};
        neg   = word[PW-1];
        if (word == '0)                           cls = PCLS_ZERO;
        else if (word == {1'b1, {(PW-1){1'b0}}})  cls = PCLS_NAR;
        else                                      cls = PCLS_NORM;
    end

endmodule

// File: rtl/posit_product.sv
module posit_product
    import posit_mac_pkg::*;
#(
    parameter int PW = 8,
    parameter int ES = 2,
    parameter int QW = 32,
    parameter int QF = 16,
    localparam int FW  = PW - 3 - ES,
    localparam int SW  = FW + 1,
    localparam int SCW = $clog2(PW * (1 << ES)) + 2
) (
    input  pcls_e                 cls_a,
    input  pcls_e                 cls_b,
    input  logic                  neg_a,
    input  logic                  neg_b,
    input  logic signed [SCW-1:0] scale_a,
    input  logic signed [SCW-1:0] scale_b,
    input  logic [SW-1:0]         sig_a,
    input  logic [SW-1:0]         sig_b,
    output logic [QW-1:0]         mag,
    output logic                  pneg,
    output logic                  povf,
    output logic                  pnar
);

    // value = prod * 2^(s - 2*FW); quire integer = value * 2^QF
    localparam int OVF_SCALE = QW - QF - 1;

    logic [2*SW-1:0]     prod;
    logic signed [SCW:0] s;
    logic [QW-1:0]       ext;
    logic [QW-1:0]       shifted;
    int                  sh;

    always_comb begin
        prod    = sig_a * sig_b;
        s       = {scale_a[SCW-1], scale_a} + {scale_b[SCW-1], scale_b};
        sh      = int'(s) - 2 * FW + QF;
        ext     = QW'(prod);
        shifted = (sh >= 0) ? (ext << sh) : (ext >> (-sh));
        pnar    = (cls_a == PCLS_NAR) || (cls_b == PCLS_NAR);
        pneg    = neg_a ^ neg_b;
        mag     = '0;
        povf    = 1'b0;
        if (!pnar && cls_a == PCLS_NORM && cls_b == PCLS_NORM) begin
            if (int'(s) >= OVF_SCALE || shifted[QW-1]) povf = 1'b1;
            else                                       mag  = shifted;
        end
    end

endmodule

// File: rtl/quire_accum.sv
module quire_accum #(
    parameter int QW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic          clr_en,
    input  logic [QW-1:0] mag,
    input  logic          pneg,
    input  logic          povf,
    input  logic          pnar,
    output logic [QW-1:0] quire,
    output logic          ovf_flag,
    output logic          nar_flag
);

    localparam logic [QW-1:0] QMAX = {1'b0, {(QW-1){1'b1}}};
    localparam logic [QW-1:0] QMIN = {1'b1, {(QW-1){1'b0}}};

    typedef struct packed {
        logic [QW-1:0] quire;
        logic          ovf;
        logic          nar;
    } qstate_t;

    qstate_t       st_d, st_q;
    logic [QW:0]   addend;
    logic [QW:0]   sum;

    always_comb begin
        st_d   = st_q;
        addend = pneg ? ({(QW+1){1'b0}} - {1'b0, mag}) : {1'b0, mag};
        sum    = {st_q.quire[QW-1], st_q.quire} + addend;
        if (clr_en) begin
            st_d = '0;
        end else if (acc_en) begin
            if (pnar) begin
                st_d.nar = 1'b1;
            end else if (povf) begin
                st_d.ovf   = 1'b1;
                st_d.quire = pneg ? QMIN : QMAX;
            end else if (sum[QW] != sum[QW-1]) begin
                st_d.ovf   = 1'b1;
                st_d.quire = sum[QW] ? QMIN : QMAX;
            end else begin
                st_d.quire = sum[QW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign quire    = st_q.quire;
    assign ovf_flag = st_q.ovf;
    assign nar_flag = st_q.nar;

    // R10
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> (quire == '0 && !ovf_flag && !nar_flag));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_en) |=> ovf_flag);

    // R5
    nar_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nar_flag && !clr_en) |=> nar_flag);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !clr_en) |=> ($stable(quire) && $stable(ovf_flag) && $stable(nar_flag)));

    // R8
    prod_ovf_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !clr_en && !pnar && povf) |=> (ovf_flag && (quire == QMAX || quire == QMIN)));

endmodule

// File: rtl/posit_quire_mac.sv
module posit_quire_mac
    import posit_mac_pkg::*;
#(
    parameter int PW = 8,
    parameter int ES = 2,
    parameter int QW = 32,
    parameter int QF = 16,
    localparam int FW  = PW - 3 - ES,
    localparam int SW  = FW + 1,
    localparam int SCW = $clog2(PW * (1 << ES)) + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic          clr_en,
    input  logic [PW-1:0] opa,
    input  logic [PW-1:0] opb,
    output logic [QW-1:0] quire,
    output logic          ovf_flag,
    output logic          nar_flag
);

    localparam logic [PW-1:0] NAR_WORD = {1'b1, {(PW-1){1'b0}}};

    pcls_e                 cls_a, cls_b;
    logic                  neg_a, neg_b;
    logic signed [SCW-1:0] scale_a, scale_b;
    logic [SW-1:0]         sig_a, sig_b;
    logic [QW-1:0]         mag;
    logic                  pneg, povf, pnar;

    posit_decode #(.PW(PW), .ES(ES)) u_deca (
        .word(opa), .cls(cls_a), .neg(neg_a), .scale(scale_a), .sig(sig_a)
    );

    posit_decode #(.PW(PW), .ES(ES)) u_decb (
        .word(opb), .cls(cls_b), .neg(neg_b), .scale(scale_b), .sig(sig_b)
    );

    posit_product #(.PW(PW), .ES(ES), .QW(QW), .QF(QF)) u_prod (
        .cls_a(cls_a), .cls_b(cls_b), .neg_a(neg_a), .neg_b(neg_b),
        .scale_a(scale_a), .scale_b(scale_b), .sig_a(sig_a), .sig_b(sig_b),
        .mag(mag), .pneg(pneg), .povf(povf), .pnar(pnar)
    );

    quire_accum #(.QW(QW)) u_acc (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .clr_en(clr_en),
        .mag(mag), .pneg(pneg), .povf(povf), .pnar(pnar),
        .quire(quire), .ovf_flag(ovf_flag), .nar_flag(nar_flag)
    );

    // R4
    zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !clr_en && (opa == '0 || opb == '0) && opa != NAR_WORD && opb != NAR_WORD)
        |=> ($stable(quire) && $stable(ovf_flag)));

    // R5
    nar_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !clr_en && (opa == NAR_WORD || opb == NAR_WORD))
        |=> ($stable(quire) && nar_flag));

endmodule

// File: tb/sim_posit_quire_mac.sv
module sim_posit_quire_mac;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        clr_en = 1'b0;
    logic [7:0]  opa = '0;
    logic [7:0]  opb = '0;
    logic [31:0] quire;
    logic        ovf_flag;
    logic        nar_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    posit_quire_mac u0 (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .clr_en(clr_en),
        .opa(opa), .opb(opb), .quire(quire), .ovf_flag(ovf_flag), .nar_flag(nar_flag)
    );

    // {clr, acc, opa, opb, expected quire, expected ovf, expected nar, requirement number}
    localparam int NV = 32;
    localparam logic [59:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'h00, 8'h00, 32'h00000000, 1'b0, 1'b0, 8'd10}, // R10 clear
        {1'b0, 1'b1, 8'h40, 8'h40, 32'h00010000, 1'b0, 1'b0, 8'd2},  // R2 1*1
        {1'b0, 1'b1, 8'h44, 8'h48, 32'h00040000, 1'b0, 1'b0, 8'd2},  // R2 1.5*2
        {1'b0, 1'b1, 8'h44, 8'h32, 32'h00047800, 1'b0, 1'b0, 8'd2},  // R2 1.5*0.3125
        {1'b0, 1'b1, 8'hC0, 8'h50, 32'h00007800, 1'b0, 1'b0, 8'd3},  // R3 -1*4
        {1'b1, 1'b1, 8'h40, 8'h40, 32'h00000000, 1'b0, 1'b0, 8'd10}, // R10 clear beats acc
        {1'b0, 1'b1, 8'h01, 8'h40, 32'h00000000, 1'b0, 1'b0, 8'd6},  // R6 2^-24 vanishes
        {1'b0, 1'b1, 8'h38, 8'h30, 32'h00002000, 1'b0, 1'b0, 8'd2},  // R2 0.5*0.25
        {1'b0, 1'b1, 8'hBC, 8'h38, 32'hFFFF6000, 1'b0, 1'b0, 8'd3},  // R3 -1.5*0.5
        {1'b0, 1'b1, 8'h00, 8'h70, 32'hFFFF6000, 1'b0, 1'b0, 8'd4},  // R4 zero operand
        {1'b0, 1'b1, 8'h11, 8'h11, 32'hFFFF6001, 1'b0, 1'b0, 8'd6},  // R6 +1.5625 lsb -> 1
        {1'b0, 1'b1, 8'h11, 8'hEF, 32'hFFFF6000, 1'b0, 1'b0, 8'd6},  // R6 -1.5625 lsb -> -1
        {1'b1, 1'b0, 8'h00, 8'h00, 32'h00000000, 1'b0, 1'b0, 8'd10}, // R10
        {1'b0, 1'b1, 8'h70, 8'h60, 32'h10000000, 1'b0, 1'b0, 8'd2},  // R2 256*16
        {1'b0, 1'b1, 8'h70, 8'h68, 32'h50000000, 1'b0, 1'b0, 8'd2},  // R2 256*64
        {1'b0, 1'b1, 8'h70, 8'h68, 32'h7FFFFFFF, 1'b1, 1'b0, 8'd7},  // R7 positive rail
        {1'b0, 1'b1, 8'hC0, 8'h40, 32'h7FFEFFFF, 1'b1, 1'b0, 8'd9},  // R9 flag sticks
        {1'b1, 1'b0, 8'h00, 8'h00, 32'h00000000, 1'b0, 1'b0, 8'd10}, // R10 flag cleared
        {1'b0, 1'b1, 8'h7F, 8'h40, 32'h7FFFFFFF, 1'b1, 1'b0, 8'd8},  // R8 maxpos product
        {1'b1, 1'b0, 8'h00, 8'h00, 32'h00000000, 1'b0, 1'b0, 8'd10}, // R10
        {1'b0, 1'b1, 8'h90, 8'h68, 32'hC0000000, 1'b0, 1'b0, 8'd3},  // R3 -256*64
        {1'b0, 1'b1, 8'h90, 8'h68, 32'h80000000, 1'b0, 1'b0, 8'd7},  // R7 exactly -2^15
        {1'b0, 1'b1, 8'h90, 8'h68, 32'h80000000, 1'b1, 1'b0, 8'd7},  // R7 negative rail
        {1'b1, 1'b0, 8'h00, 8'h00, 32'h00000000, 1'b0, 1'b0, 8'd10}, // R10
        {1'b0, 1'b1, 8'hC0, 8'h70, 32'hFF000000, 1'b0, 1'b0, 8'd3},  // R3 -1*256
        {1'b0, 1'b1, 8'h90, 8'h60, 32'hEF000000, 1'b0, 1'b0, 8'd3},  // R3 -256*16
        {1'b0, 1'b1, 8'h80, 8'h40, 32'hEF000000, 1'b0, 1'b1, 8'd5},  // R5 NaR in opa
        {1'b0, 1'b1, 8'h70, 8'h70, 32'h7FFFFFFF, 1'b1, 1'b1, 8'd8},  // R8 2^16 product
        {1'b0, 1'b0, 8'h70, 8'h70, 32'h7FFFFFFF, 1'b1, 1'b1, 8'd11}, // R11 idle
        {1'b1, 1'b0, 8'h00, 8'h00, 32'h00000000, 1'b0, 1'b0, 8'd10}, // R10 both flags
        {1'b0, 1'b1, 8'h90, 8'h70, 32'h80000000, 1'b1, 1'b0, 8'd8},  // R8 negative product
        {1'b0, 1'b1, 8'h40, 8'h80, 32'h80000000, 1'b1, 1'b1, 8'd5}   // R5 NaR in opb
    };

    task automatic check(input string req, input logic [31:0] q_exp,
                         input logic o_exp, input logic n_exp);
        checks++;
        if ({quire, ovf_flag, nar_flag} !== {q_exp, o_exp, n_exp}) begin
            fails++;
            $display("FAIL %s: quire=%h ovf=%b nar=%b, expected quire=%h ovf=%b nar=%b",
                     req, quire, ovf_flag, nar_flag, q_exp, o_exp, n_exp);
        end
    endtask

    task automatic step(input logic c, input logic a, input logic [7:0] x, input logic [7:0] y);
        clr_en = c;
        acc_en = a;
        opa    = x;
        opb    = y;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 during reset", 32'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 32'h0, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][59], VEC[i][58], VEC[i][57:50], VEC[i][49:42]);
            check($sformatf("R%0d row %0d", VEC[i][7:0], i),
                  VEC[i][41:10], VEC[i][9], VEC[i][8]);
        end

        // R2: strobe held two edges adds the product twice
        step(1'b1, 1'b0, 8'h00, 8'h00);
        clr_en = 1'b0; acc_en = 1'b1; opa = 8'h40; opb = 8'h40;
        @(posedge clk); @(negedge clk);
        check("R2 first held edge", 32'h00010000, 1'b0, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R2 second held edge", 32'h00020000, 1'b0, 1'b0);

        // R11: operand changes with strobes low leave state alone
        step(1'b0, 1'b0, 8'h7F, 8'h7F);
        step(1'b0, 1'b0, 8'h80, 8'h80);
        check("R11 idle operands", 32'h00020000, 1'b0, 1'b0);

        // R1: reset in the middle of a run
        step(1'b0, 1'b1, 8'h70, 8'h70);
        check("R8 before reset", 32'h7FFFFFFF, 1'b1, 1'b0);
        acc_en = 1'b0;
        rst_n  = 1'b0;
        #1;
        check("R1 async reset", 32'h0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after second reset", 32'h0, 1'b0, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule